// File: doc/BRIEF.md
# Programmed-I/O Read Port

This block is the device side of an asynchronous parallel host bus, limited to reads. The host drives an active-low chip select, an active-low read enable and a 7-bit word address. The block runs on a fast internal clock and passes both strobes through synchronizer chains. It treats the moment both synchronized strobes are low as the start of a read cycle. At that edge it captures the address and takes a snapshot of the selected word. The snapshot source is an identity constant, a free-running tick counter, a count of started cycles, a status word, or the head of one of two receive FIFOs. It then drives that snapshot onto a 32-bit data bus through per-half output enables until either strobe is released.

A device-side agent fills the two FIFOs through simple push inputs. A host read of a FIFO address pops one entry. Reading an empty FIFO returns zero and records a sticky underrun flag. A strap input selects a 16-bit bus, in which the upper half-word is never enabled. The nanosecond limits of the bus become clock-cycle counts: `DV_DELAY` delays the data drivers, and `GAP_CYCLES` sets how long the strobes must be apart before a new cycle is accepted.

Top module: `pio_rd_port`

## Requirements
- R1: A cycle begins when both strobes are low, whichever falls first. `doe[0]` rises on the (3+DV_DELAY)th rising clock edge after the later strobe falls, and not before.
- R2: The cycle ends when either strobe rises. `doe` and `dout` return to zero on the 2nd rising edge after that.
- R3: A new cycle begins only if, after synchronization, the strobes were not both low for at least GAP_CYCLES clock periods. A shorter gap starts no cycle and drives nothing until both strobes are released and asserted again.
- R4: Word address 0x01 returns a tick counter that counts clock edges since reset. Its value is taken at cycle start and stays unchanged on `dout` for the whole cycle.
- R5: Word address 0x02 returns the number of cycles started before the current one.
- R6: Word address 0x00 returns the parameter ID_VAL.
- R7: Word address 0x10 pops one entry of the data FIFO per cycle, in push order. A push into a full FIFO is dropped.
- R8: Word address 0x11 pops one entry of the status FIFO per cycle, in push order.
- R9: A pop of an empty FIFO returns zero and sets a sticky flag. The flags are readable at word address 0x03: bit 0 for the data FIFO and bit 1 for the status FIFO. The same word carries the data FIFO level in bits 15:8 and the status FIFO level in bits 23:16. All of it is sampled at cycle start, before the pop.
- R10: Any other address returns zero and changes no FIFO level or flag.
- R11: With `bus16` high, `doe[1]` stays low and `dout[31:16]` stays zero. The low half keeps the same data and timing as a 32-bit read.
- R12: Outside a cycle, `doe` and `dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read enable, active low, asynchronous |
| addr | input | 7 | Word address, captured at cycle start |
| bus16 | input | 1 | 16-bit bus width strap |
| dout | output | 32 | Read data bus, zero when not enabled |
| doe | output | 2 | Output enables: bit 0 low half, bit 1 high half |
| rxd_push | input | 1 | Push strobe for the data FIFO |
| rxd_wdata | input | 32 | Data FIFO write word |
| rxs_push | input | 1 | Push strobe for the status FIFO |
| rxs_wdata | input | 32 | Status FIFO write word |

## Verification
Each strobe change is applied on a falling clock edge, so the bench can count rising edges exactly. It samples `doe` one edge before it is due to rise (3+DV_DELAY edges after the later strobe falls), then at the edge where it rises, and it captures `dout` at that second point. After a strobe is released, the bench samples one edge before and exactly at the 2nd edge, where the drivers must be off. The snapshot is compared on the three falling edges that follow. For the tick counter, the difference between two reads must equal the spacing of their strobe edges. Gap handling is probed with strobe-high gaps of exactly one and exactly two periods. A sweep over all 128 addresses compares each result with a model of the FIFO levels, the flags and the start count.

// File: rtl/pio_rd_pkg.sv
// Package pio_rd_pkg
// Purpose: shared widths, word addresses and the address decoder for the
//          programmed-I/O read port.
// Assumes: a 7-bit word address and a 32-bit data word.
package pio_rd_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_IDENT  = 7'h00;
    localparam logic [ADDR_W-1:0] A_TICKS  = 7'h01;
    localparam logic [ADDR_W-1:0] A_STARTS = 7'h02;
    localparam logic [ADDR_W-1:0] A_STATUS = 7'h03;
    localparam logic [ADDR_W-1:0] A_RXDATA = 7'h10;
    localparam logic [ADDR_W-1:0] A_RXSTAT = 7'h11;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_TICKS,
        SEL_STARTS,
        SEL_STATUS,
        SEL_RXDATA,
        SEL_RXSTAT
    } sel_e;

    // Map a word address to the source it selects.
    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            A_IDENT:  return SEL_IDENT;
            A_TICKS:  return SEL_TICKS;
            A_STARTS: return SEL_STARTS;
            A_STATUS: return SEL_STATUS;
            A_RXDATA: return SEL_RXDATA;
            A_RXSTAT: return SEL_RXSTAT;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pio_rd_strobe.sv
// Module pio_rd_strobe
// Purpose: synchronizes the two active-low strobes, detects the start of a
//          read cycle, enforces the minimum gap between cycles and produces
//          the delayed driver enable.
// Assumes: strobes are asynchronous to clk. SYNC_STAGES >= 2. A cycle is
//          live only while both synchronized strobes stay low.
module pio_rd_strobe #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYCLES  = 2,
    parameter int DV_DELAY    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    output logic start,
    output logic live,
    output logic drive
);

    localparam int GAP_W = $clog2(GAP_CYCLES + 2);
    localparam int DV_W  = $clog2(DV_DELAY + 2);

    logic [1:0]       strobe_n;
    logic [1:0]       strobe_s;
    logic             act;
    logic             act_q;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_ok;
    logic [DV_W-1:0]  dv_cnt;

    assign strobe_n = {rd_n, cs_n};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift the raw strobe through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], strobe_n[g]};
        end
        assign strobe_s[g] = chain[SYNC_STAGES-1];
    end

    assign act    = ~|strobe_s;
    assign gap_ok = gap_cnt >= GAP_W'(GAP_CYCLES);
    assign start  = act & ~act_q & gap_ok;
    assign drive  = live & act & (dv_cnt >= DV_W'(DV_DELAY));

    // Remember the previous combined strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // Count idle periods between cycles; saturate once the gap is met.
    always_ff @(posedge clk) begin
        if (!rst_n)       gap_cnt <= GAP_W'(GAP_CYCLES);
        else if (act)     gap_cnt <= '0;
        else if (!gap_ok) gap_cnt <= gap_cnt + GAP_W'(1);
    end

    // Hold the cycle flag from start until either strobe releases.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= act & (live | start);
    end

    // Count cycles since start to delay the data drivers.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  dv_cnt <= '0;
        else if (start)                              dv_cnt <= '0;
        else if (live && dv_cnt < DV_W'(DV_DELAY))   dv_cnt <= dv_cnt + DV_W'(1);
    end

    // R1
    live_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> live);

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> !start);

    // R2
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> !live || !drive);

endmodule

// File: rtl/pio_rd_fifo.sv
// Module pio_rd_fifo
// Purpose: small first-word-fall-through FIFO read by the host port.
// Assumes: the head word is valid when level is non-zero. A push while full
//          and a pop while empty are both ignored.
module pio_rd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (level == '0);
    assign do_push = push & (level != LVL_W'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers with wrap and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> level == '0);

endmodule

// File: rtl/pio_rd_port.sv
// Module pio_rd_port
// Purpose: host-facing read port. Takes a snapshot of the addressed word at
//          cycle start, pops FIFOs, keeps sticky underrun flags and drives
//          the data bus with per-half enables.
// Assumes: the address is stable when the cycle start is detected, bus16 is
//          a static strap, and FIFO_DEPTH <= 255 so each level fits 8 bits.
module pio_rd_port
    import pio_rd_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          GAP_CYCLES  = 2,
    parameter int          DV_DELAY    = 0,
    parameter int          FIFO_DEPTH  = 4,
    parameter int          CNT_W       = 32,
    parameter logic [31:0] ID_VAL      = 32'h5A17_C0DE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic [6:0]  addr,
    input  logic        bus16,
    output logic [31:0] dout,
    output logic [1:0]  doe,
    input  logic        rxd_push,
    input  logic [31:0] rxd_wdata,
    input  logic        rxs_push,
    input  logic [31:0] rxs_wdata
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int HALF  = WORD_W / 2;

    logic              start;
    logic              live;
    logic              drive;
    sel_e              sel;
    logic [CNT_W-1:0]  ticks;
    logic [CNT_W-1:0]  starts;
    logic [1:0]        under_q;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] status_w;

    logic [1:0]        push_v;
    logic [1:0]        pop_v;
    logic [1:0]        empty_v;
    logic [WORD_W-1:0] wdata_v [2];
    logic [WORD_W-1:0] head_v  [2];
    logic [LVL_W-1:0]  lvl_v   [2];

    pio_rd_strobe #(
        .SYNC_STAGES (SYNC_STAGES),
        .GAP_CYCLES  (GAP_CYCLES),
        .DV_DELAY    (DV_DELAY)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .start (start),
        .live  (live),
        .drive (drive)
    );

    assign sel        = decode(addr);
    assign push_v     = {rxs_push, rxd_push};
    assign wdata_v[0] = rxd_wdata;
    assign wdata_v[1] = rxs_wdata;
    assign pop_v[0]   = start & (sel == SEL_RXDATA);
    assign pop_v[1]   = start & (sel == SEL_RXSTAT);

    for (genvar q = 0; q < 2; q++) begin : g_fifo
        pio_rd_fifo #(
            .WIDTH (WORD_W),
            .DEPTH (FIFO_DEPTH),
            .LVL_W (LVL_W)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[q]),
            .wdata (wdata_v[q]),
            .pop   (pop_v[q]),
            .head  (head_v[q]),
            .level (lvl_v[q]),
            .empty (empty_v[q])
        );
    end

    // Free-running tick counter, one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) ticks <= '0;
        else        ticks <= ticks + CNT_W'(1);
    end

    // Count accepted cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n)     starts <= '0;
        else if (start) starts <= starts + CNT_W'(1);
    end

    // Set the sticky underrun flag of a FIFO popped while empty.
    always_ff @(posedge clk) begin
        if (!rst_n) under_q <= '0;
        else        under_q <= under_q | (pop_v & empty_v);
    end

    assign status_w = {8'h00, 8'(lvl_v[1]), 8'(lvl_v[0]), 6'h00, under_q};

    // Select the word that the current address reads.
    always_comb begin
        case (sel)
            SEL_IDENT:  rd_mux = ID_VAL;
            SEL_TICKS:  rd_mux = WORD_W'(ticks);
            SEL_STARTS: rd_mux = WORD_W'(starts);
            SEL_STATUS: rd_mux = status_w;
            SEL_RXDATA: rd_mux = empty_v[0] ? '0 : head_v[0];
            SEL_RXSTAT: rd_mux = empty_v[1] ? '0 : head_v[1];
            default:    rd_mux = '0;
        endcase
    end

    // Capture the snapshot once, at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_q <= '0;
        else if (start) data_q <= rd_mux;
    end

    assign doe[0]          = drive;
    assign doe[1]          = drive & ~bus16;
    assign dout[HALF-1:0]  = doe[0] ? data_q[HALF-1:0] : '0;
    assign dout[WORD_W-1:HALF] = doe[1] ? data_q[WORD_W-1:HALF] : '0;

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(live) |-> $stable(data_q));

    // R11
    half_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus16 |-> doe[1] == 1'b0 && dout[WORD_W-1:HALF] == '0);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> doe == 2'b00 && dout == '0);

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && sel == SEL_NONE |=> under_q == $past(under_q));

endmodule

// File: tb/pio_rd_port_test.sv
`timescale 1ns/1ps
module pio_rd_port_test;

    localparam int          DV    = 1;
    localparam int          GAP   = 2;
    localparam int          DEPTH = 4;
    localparam logic [31:0] ID    = 32'h5A17_C0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [6:0]  addr = '0;
    logic        bus16 = 1'b0;
    logic [31:0] dout;
    logic [1:0]  doe;
    logic        rxd_push = 1'b0;
    logic [31:0] rxd_wdata = '0;
    logic        rxs_push = 1'b0;
    logic [31:0] rxs_wdata = '0;

    int checks = 0;
    int errors = 0;
    int nstarts = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_rd_port #(
        .GAP_CYCLES (GAP),
        .DV_DELAY   (DV),
        .FIFO_DEPTH (DEPTH),
        .ID_VAL     (ID)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .addr      (addr),
        .bus16     (bus16),
        .dout      (dout),
        .doe       (doe),
        .rxd_push  (rxd_push),
        .rxd_wdata (rxd_wdata),
        .rxs_push  (rxs_push),
        .rxs_wdata (rxs_wdata)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One full read: strobe order 0 = cs first, 1 = rd first, 2 = together.
    task automatic rd(input logic [6:0] a, input int order, input int idle,
                      output logic [31:0] val, output longint t_fall);
        logic [1:0] exp_oe;
        exp_oe = bus16 ? 2'b01 : 2'b11;
        @(negedge clk);
        addr = a;
        if (order == 0) begin
            cs_n = 1'b0; @(negedge clk); rd_n = 1'b0;
        end else if (order == 1) begin
            rd_n = 1'b0; @(negedge clk); cs_n = 1'b0;
        end else begin
            cs_n = 1'b0; rd_n = 1'b0;
        end
        t_fall = longint'($time);
        repeat (2 + DV) @(posedge clk);
        @(negedge clk);
        chk(doe == 2'b00, "R1 early", 32'(doe), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk(doe == exp_oe, "R1 on", 32'(doe), 32'(exp_oe));
        val = dout;
        repeat (3) begin
            @(negedge clk);
            chk(dout == val, "R4 hold", dout, val);
        end
        if (order == 1) rd_n = 1'b1; else cs_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(doe == exp_oe, "R2 still on", 32'(doe), 32'(exp_oe));
        @(posedge clk);
        @(negedge clk);
        chk(doe == 2'b00 && dout == '0, "R2 off", dout, 32'h0);
        cs_n = 1'b1;
        rd_n = 1'b1;
        nstarts++;
        repeat (idle) @(negedge clk);
    endtask

    task automatic push_w(input int which, input logic [31:0] d);
        @(negedge clk);
        if (which == 0) begin rxd_push = 1'b1; rxd_wdata = d; end
        else            begin rxs_push = 1'b1; rxs_wdata = d; end
        @(negedge clk);
        rxd_push = 1'b0;
        rxs_push = 1'b0;
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        longint t1;
        longint t2;
        logic [31:0] exp;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(doe == 2'b00 && dout == '0, "R12 reset", dout, 32'h0);

        // R6 and R1: every strobe order
        for (int o = 0; o < 3; o++) begin
            rd(7'h00, o, 3, v, t1);
            chk(v == ID, "R6 ident", v, ID);
        end

        // R5 start count
        rd(7'h02, 2, 3, v, t1);
        chk(v == 32'(nstarts - 1), "R5 starts", v, 32'(nstarts - 1));

        // R4 tick spacing between two reads
        rd(7'h01, 2, 3, v, t1);
        rd(7'h01, 0, 7, v2, t2);
        chk(v2 - v == 32'((t2 - t1) / 8), "R4 ticks", v2 - v, 32'((t2 - t1) / 8));

        // R9 initial status
        rd(7'h03, 2, 3, v, t1);
        chk(v == 32'h0, "R9 status init", v, 32'h0);

        // R7 data FIFO with one dropped push
        for (int i = 0; i < DEPTH + 1; i++) push_w(0, 32'hD000_0000 + 32'(i * 17));
        rd(7'h03, 2, 3, v, t1);
        chk(v == 32'h0000_0400, "R9 level full", v, 32'h0000_0400);
        for (int i = 0; i < DEPTH; i++) begin
            rd(7'h10, 2, 3, v, t1);
            chk(v == 32'hD000_0000 + 32'(i * 17), "R7 pop order", v, 32'hD000_0000 + 32'(i * 17));
        end
        rd(7'h10, 2, 3, v, t1);
        chk(v == 32'h0, "R9 empty data", v, 32'h0);
        rd(7'h03, 2, 3, v, t1);
        chk(v == 32'h0000_0001, "R9 data flag", v, 32'h0000_0001);

        // R8 status FIFO
        push_w(1, 32'h5E00_0001);
        push_w(1, 32'h5E00_0002);
        rd(7'h03, 2, 3, v, t1);
        chk(v == 32'h0002_0001, "R9 status level", v, 32'h0002_0001);
        rd(7'h11, 1, 3, v, t1);
        chk(v == 32'h5E00_0001, "R8 pop first", v, 32'h5E00_0001);
        rd(7'h11, 0, 3, v, t1);
        chk(v == 32'h5E00_0002, "R8 pop second", v, 32'h5E00_0002);
        rd(7'h11, 2, 3, v, t1);
        chk(v == 32'h0, "R9 empty status", v, 32'h0);
        rd(7'h03, 2, 3, v, t1);
        chk(v == 32'h0000_0003, "R9 both flags", v, 32'h0000_0003);

        // R10 unmapped reads leave levels and flags unchanged
        push_w(0, 32'hA5A5_0F0F);
        rd(7'h05, 2, 3, v, t1);
        chk(v == 32'h0, "R10 unmapped 05", v, 32'h0);
        rd(7'h7F, 0, 3, v, t1);
        chk(v == 32'h0, "R10 unmapped 7F", v, 32'h0);
        rd(7'h12, 1, 3, v, t1);
        chk(v == 32'h0, "R10 unmapped 12", v, 32'h0);
        rd(7'h03, 2, 3, v, t1);
        chk(v == 32'h0000_0103, "R10 no side effect", v, 32'h0000_0103);
        rd(7'h10, 2, 3, v, t1);
        chk(v == 32'hA5A5_0F0F, "R7 after unmapped", v, 32'hA5A5_0F0F);

        // R11 16-bit bus
        bus16 = 1'b1;
        rd(7'h00, 2, 3, v, t1);
        chk(v == {16'h0, ID[15:0]}, "R11 ident half", v, {16'h0, ID[15:0]});
        rd(7'h02, 0, 3, v, t1);
        chk(v == {16'h0, 16'(nstarts - 1)}, "R11 starts half", v, {16'h0, 16'(nstarts - 1)});
        bus16 = 1'b0;

        // R3 gap of one period: no new cycle
        @(negedge clk);
        addr = 7'h02; cs_n = 1'b0; rd_n = 1'b0;
        repeat (3 + DV) @(posedge clk);
        @(negedge clk);
        chk(doe == 2'b11, "R3 first on", 32'(doe), 32'h3);
        chk(dout == 32'(nstarts), "R5 gap first", dout, 32'(nstarts));
        nstarts++;
        rd_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(doe == 2'b00, "R3 short gap", 32'(doe), 32'h0);
        end
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 gap of exactly GAP periods: new cycle
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (3 + DV) @(posedge clk);
        @(negedge clk);
        chk(dout == 32'(nstarts), "R3 before gap", dout, 32'(nstarts));
        nstarts++;
        rd_n = 1'b1;
        repeat (GAP) @(negedge clk);
        rd_n = 1'b0;
        repeat (3 + DV) @(posedge clk);
        @(negedge clk);
        chk(doe == 2'b11, "R3 exact gap on", 32'(doe), 32'h3);
        chk(dout == 32'(nstarts), "R3 exact gap data", dout, 32'(nstarts));
        nstarts++;
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(doe == 2'b00 && dout == '0, "R12 idle", dout, 32'h0);

        // Sweep every address except the tick counter against the model
        for (int a = 0; a < 128; a++) begin
            if (a != 1) begin
                case (a)
                    0:       exp = ID;
                    2:       exp = 32'(nstarts);
                    3:       exp = 32'h0000_0003;
                    default: exp = 32'h0;
                endcase
                rd(7'(a), a % 3, 3, v, t1);
                chk(v == exp, "R10 sweep", v, exp);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule